// File: doc/BRIEF.md
# Pixel Layer Merge, Edge Clip and Color Stage

This block is the last per-pixel step of a raster video controller. In each cycle it receives one pixel's worth of layer data: a background palette index and the color already looked up for it, a sprite palette index with its color and a priority flag, the backdrop color, and the current horizontal position. It holds the 8-bit display-mask register, which software writes through a simple write strobe.

The mask register sets four things. It turns each layer on or off. It chooses whether each layer may show in the leftmost eight columns. It can force a monochrome output. It supplies three color-emphasis bits. The block merges the two layers by transparency and priority. It masks the result when monochrome is on, and registers the 6-bit color and the emphasis bits with one cycle of latency.

Top module: `pix_color_stage`

## Requirements
- R1: While reset is asserted and after it is released, the mask register holds 0x00, `color_out` is 0 and `emph_out` is 0. With the reset mask, both layers are disabled and every pixel shows the backdrop color.
- R2: A write (`mask_we`=1) loads `mask_wdata` into the mask register at the clock edge. The pixel presented in the write cycle still uses the old mask, and pixels from the next cycle use the new one.
- R3: Mask bit 4 enables the sprite layer and mask bit 3 enables the background layer. A disabled layer is treated as transparent.
- R4: When `pix_x` is in the range 0 to 7, a sprite pixel is hidden unless mask bit 2 is 1, and a background pixel is hidden unless mask bit 1 is 1. A hidden pixel is transparent. At `pix_x` of 8 and above, these bits have no effect.
- R5: A palette index whose two low bits are 00 is transparent. When neither layer is opaque, the output is `backdrop_color`.
- R6: When both layers are opaque, the sprite is shown if `spr_behind`=0 and the background is shown if `spr_behind`=1. When only one layer is opaque, that layer is shown.
- R7: When mask bit 0 is 1, the selected 6-bit color is ANDed with 0x30 before it is output.
- R8: `emph_out[2]`, `emph_out[1]` and `emph_out[0]` equal mask bits 7 (blue), 6 (green) and 5 (red). This holds regardless of mask bit 0.
- R9: `color_out` and `emph_out` appear one clock after the inputs that produce them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | Mask register write data |
| pix_x | input | 9 | Horizontal pixel position |
| bg_pix | input | 4 | Background palette index (low two bits 00 = transparent) |
| bg_color | input | 6 | Color for the background pixel |
| spr_pix | input | 4 | Sprite palette index (low two bits 00 = transparent) |
| spr_color | input | 6 | Color for the sprite pixel |
| spr_behind | input | 1 | 1 puts the sprite behind an opaque background |
| backdrop_color | input | 6 | Color shown when no layer is opaque |
| color_out | output | 6 | Registered final color index |
| emph_out | output | 3 | Registered emphasis bits {blue, green, red} |

## Verification
Assertions check the following on every cycle:
- the reset values;
- that monochrome always clears the four low color bits;
- that the emphasis output only changes after a mask change;
- that the backdrop is shown when both layers are disabled or both are clipped in the left columns.

The bench's scenarios cover the remaining behaviour:
- priority between two opaque layers;
- transparency decided by the index;
- the exact boundary between columns 7 and 8;
- the old-mask/new-mask timing of a register write.

The bench checks these against a model of its own for all 32 combinations of the low mask bits.

// File: rtl/pix_color_stage.sv
module pix_color_stage #(
  parameter int XW    = 9,
  parameter int PIXW  = 4,
  parameter int CW    = 6,
  parameter int CLIPW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mask_we,
  input  logic [7:0]      mask_wdata,
  input  logic [XW-1:0]   pix_x,
  input  logic [PIXW-1:0] bg_pix,
  input  logic [CW-1:0]   bg_color,
  input  logic [PIXW-1:0] spr_pix,
  input  logic [CW-1:0]   spr_color,
  input  logic            spr_behind,
  input  logic [CW-1:0]   backdrop_color,
  output logic [CW-1:0]   color_out,
  output logic [2:0]      emph_out
);
  localparam logic [CW-1:0] GRAY_KEEP = {2'b11, {(CW-2){1'b0}}};
  localparam logic [XW-1:0] CLIP_END  = XW'(CLIPW);

  logic [7:0]    mask_q;
  logic          in_edge, bg_vis, spr_vis, spr_wins;
  logic [CW-1:0] merged, shaded;

  assign in_edge  = pix_x < CLIP_END;
  assign bg_vis   = mask_q[3] && (mask_q[1] || !in_edge) && (bg_pix[1:0] != 2'b00);
  assign spr_vis  = mask_q[4] && (mask_q[2] || !in_edge) && (spr_pix[1:0] != 2'b00);
  assign spr_wins = spr_vis && (!bg_vis || !spr_behind);
  assign merged   = spr_wins ? spr_color : (bg_vis ? bg_color : backdrop_color);
  assign shaded   = mask_q[0] ? (merged & GRAY_KEEP) : merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= 8'h00;
      color_out <= '0;
      emph_out  <= 3'b000;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      color_out <= shaded;
      emph_out  <= mask_q[7:5];
    end
  end

  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |=> (mask_q == 8'h00 && color_out == '0 && emph_out == 3'b000));

  p_write_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> mask_q == $past(mask_wdata));

  p_layers_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_q[3] && !mask_q[4] && !mask_q[0]) |=> color_out == $past(backdrop_color));

  p_edge_clip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_edge && mask_q[2:1] == 2'b00 && !mask_q[0]) |=> color_out == $past(backdrop_color));

  p_gray_low_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q[0] |=> color_out[CW-3:0] == '0);

  p_emph_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mask_q) |=> $stable(emph_out));
endmodule

// File: tb/pix_color_stage_test.sv
module pix_color_stage_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mask_we = 1'b0;
  logic [7:0] mask_wdata = 8'h00;
  logic [8:0] pix_x = '0;
  logic [3:0] bg_pix = '0, spr_pix = '0;
  logic [5:0] bg_color = '0, spr_color = '0, backdrop_color = '0;
  logic       spr_behind = 1'b0;
  logic [5:0] color_out;
  logic [2:0] emph_out;

  int checks = 0;
  int errors = 0;
  logic [7:0] model_mask = 8'h00;
  logic       done = 1'b0;

  typedef struct {
    logic [5:0] col;
    logic [2:0] emp;
    string      tag;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  pix_color_stage uut (
    .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .pix_x(pix_x), .bg_pix(bg_pix), .bg_color(bg_color), .spr_pix(spr_pix),
    .spr_color(spr_color), .spr_behind(spr_behind), .backdrop_color(backdrop_color),
    .color_out(color_out), .emph_out(emph_out));

  function automatic logic [5:0] expect_col(logic [7:0] m, logic [8:0] x,
      logic [3:0] bp, logic [5:0] bc, logic [3:0] sp, logic [5:0] sc,
      logic pri, logic [5:0] bd);
    logic left, b_ok, s_ok;
    logic [5:0] r;
    left = (x <= 9'd7);
    b_ok = (bp[1:0] != 0) && m[3] && !(left && !m[1]);
    s_ok = (sp[1:0] != 0) && m[4] && !(left && !m[2]);
    if (s_ok && b_ok) r = pri ? bc : sc;
    else if (s_ok) r = sc;
    else if (b_ok) r = bc;
    else r = bd;
    if (m[0]) r = {r[5:4], 4'b0000};
    return r;
  endfunction

  task automatic check(string tag, logic [5:0] ac, logic [2:0] ae,
                       logic [5:0] ec, logic [2:0] ee);
    checks++;
    if (ac !== ec || ae !== ee) begin
      errors++;
      $display("FAIL %s color=%h emph=%b expected color=%h emph=%b", tag, ac, ae, ec, ee);
    end
  endtask

  task automatic pixel(string tag, logic [8:0] x, logic [3:0] bp, logic [5:0] bc,
      logic [3:0] sp, logic [5:0] sc, logic pri, logic [5:0] bd,
      logic we = 1'b0, logic [7:0] wd = 8'h00);
    item_t it;
    @(negedge clk);
    pix_x = x; bg_pix = bp; bg_color = bc; spr_pix = sp; spr_color = sc;
    spr_behind = pri; backdrop_color = bd; mask_we = we; mask_wdata = wd;
    it.col = expect_col(model_mask, x, bp, bc, sp, sc, pri, bd);
    it.emp = model_mask[7:5];
    it.tag = tag;
    sb.push_back(it);
    if (we) model_mask = wd;
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check(it.tag, color_out, emph_out, it.col, it.emp);
    end
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog color=%h emph=%b expected completion", color_out, emph_out);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8:0] xs[5];
    xs = '{9'd0, 9'd7, 9'd8, 9'd9, 9'd255};
    repeat (3) @(negedge clk);
    check("R1 reset", color_out, emph_out, 6'h00, 3'b000);
    rst_n = 1'b1;
    // R1: reset mask disables both layers, backdrop shows
    pixel("R1 mask-zero", 9'd40, 4'h1, 6'h11, 4'h2, 6'h22, 1'b0, 6'h0F);
    // R2: write cycle uses old mask, next uses new
    pixel("R2 old-mask", 9'd40, 4'h1, 6'h11, 4'h2, 6'h22, 1'b0, 6'h0F, 1'b1, 8'hB8);
    pixel("R2 new-mask", 9'd40, 4'h1, 6'h11, 4'h2, 6'h22, 1'b0, 6'h0F);
    // R6 priority
    pixel("R6 sprite-front", 9'd100, 4'h3, 6'h2A, 4'h5, 6'h15, 1'b0, 6'h01);
    pixel("R6 sprite-behind", 9'd100, 4'h3, 6'h2A, 4'h5, 6'h15, 1'b1, 6'h01);
    pixel("R6 behind-bg-clear", 9'd100, 4'h4, 6'h2A, 4'h5, 6'h15, 1'b1, 6'h01);
    // R5 transparency
    pixel("R5 both-clear", 9'd100, 4'hC, 6'h2A, 4'h8, 6'h15, 1'b0, 6'h3D);
    // R4 boundary with clip active
    pixel("R4 x7-hidden", 9'd7, 4'h3, 6'h2A, 4'h1, 6'h15, 1'b0, 6'h06);
    pixel("R4 x8-shown", 9'd8, 4'h3, 6'h2A, 4'h1, 6'h15, 1'b0, 6'h06);
    // R7/R8 gray with emphasis held
    pixel("R7 gray-write", 9'd100, 4'h3, 6'h3F, 4'h0, 6'h00, 1'b0, 6'h00, 1'b1, 8'hF9);
    pixel("R7 gray-mask", 9'd100, 4'h3, 6'h3F, 4'h0, 6'h00, 1'b0, 6'h00);
    pixel("R8 emph-under-gray", 9'd100, 4'h3, 6'h1B, 4'h0, 6'h00, 1'b0, 6'h00);
    // R9: back-to-back distinct values, each one cycle later
    pixel("R9 seq-a", 9'd50, 4'h0, 6'h00, 4'h0, 6'h00, 1'b0, 6'h05, 1'b1, 8'h18);
    pixel("R9 seq-b", 9'd50, 4'h0, 6'h00, 4'h0, 6'h00, 1'b0, 6'h0A);
    pixel("R9 seq-c", 9'd50, 4'h0, 6'h00, 4'h0, 6'h00, 1'b0, 6'h14);
    // Sweep: R3 R4 R5 R6 R7 R8 over all low mask bit combos
    for (int m = 0; m < 32; m++) begin
      pixel("R3 R8 sweep-write", 9'd200, 4'h0, 6'h00, 4'h0, 6'h00, 1'b0, 6'h07,
            1'b1, {3'(m % 8), 5'(m)});
      foreach (xs[i]) begin
        for (int t = 0; t < 4; t++) begin
          for (int p = 0; p < 2; p++) begin
            pixel("R3 R4 R5 R6 R7 sweep", xs[i], {2'(t), 2'(t & 1 ? 1 : 0)}, 6'h2D,
                  {2'(m), 2'(t & 2 ? 3 : 0)}, 6'h1E, 1'(p), 6'h33);
          end
        end
      end
    end
    @(negedge clk);
    mask_we = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule